// File: doc/BRIEF.md
# Package Idle-Depth Controller

This block chooses the idle depth of a whole multi-core processor package. Each core reports its own idle depth on a small encoded field. The platform supplies three independent permission bits, one each for the light, medium and deep package idle states, and the last-level cache reports when it has been emptied. From these the controller picks the deepest package state that every core and every permission allows. It then reports that state, whether the package can still answer snoops, whether the cache sizer should start emptying the cache, and a one-cycle pulse when the package comes back to full activity.

The inputs are first captured in registers. The package state is updated on the following edge. So any change at the inputs shows up on the outputs after two rising clock edges. The deepest state is held back while the cache still holds data. During that wait the package sits in the medium state and asks for a flush. Once the flush is reported, the package drops into the deep state and stops being snoopable. Any core going active brings the package back to active, whichever idle state it was in.

Top module: `pkg_idle_ctrl`

## Requirements
- R1: Core fields and the package state output share one 2-bit encoding: 0 active, 1 light idle (C3), 2 medium idle (C6), 3 deep idle (C7). Core k uses bits [2k+1:2k] of the core bus. After reset the package state is 0 and the snoop, flush-request and wake outputs are all 0.
- R2: The package state is 1 when the shallowest core is at 1 or deeper, the light grant is high, and neither R3 nor R4 applies.
- R3: The package state is 2 when the shallowest core is at 2 or deeper, the medium grant is high, R4 does not apply, and either the deep grant is low or every core is at 3.
- R4: The package state is 3 only when every core is at 3, the deep grant is high and the cache-flushed flag is high.
- R5: The snoop output is high exactly when the package state is 1 or 2. It is low in states 0 and 3.
- R6: The flush request is high while every sampled core is at 3 and the cache-flushed flag is low. It is low in package state 3.
- R7: If any core is at 0, the package state becomes 0. The wake output is high for exactly the first cycle in which the package state is 0 after being non-zero.
- R8: When grants are withdrawn, the package settles to the deepest state the remaining grants allow. It never holds a state whose grant is low.
- R9: An input change is captured on the first rising edge and reaches the outputs on the second. After only one edge, the outputs still show the earlier decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coreState | input | 2*NUM_CORES | Packed per-core idle depth, 2 bits per core |
| grantC3 | input | 1 | Platform permits light package idle |
| grantC6 | input | 1 | Platform permits medium package idle |
| grantC7 | input | 1 | Platform permits deep package idle |
| cacheFlushed | input | 1 | Last-level cache reports fully emptied |
| pkgState | output | 2 | Current package idle depth |
| snoopable | output | 1 | Package can still answer snoops |
| flushReq | output | 1 | Request to the cache sizer to empty the cache |
| wake | output | 1 | One-cycle pulse on return to active |

## Verification
Two functions can fall in the same cycle: the flush finishing, which would allow the deep state, and a core wake event, which forces the package to active. The bench sets up this race by placing all cores at the deep level with the deep grant high and no flush, so the package waits in medium idle with a flush request. It then raises the flushed flag and wakes one core on the same clock. The bench expects the wake to win: the package goes to active with a wake pulse, the flush request drops, and the snoop output goes low. The deep state must never be seen.

// File: rtl/pkg_idle_types.sv
package pkg_idle_types;

  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    PS_ACTIVE = 2'd0,
    PS_C3     = 2'd1,
    PS_C6     = 2'd2,
    PS_C7     = 2'd3
  } pstate_e;

  // Sampled view handed from datapath to control
  typedef struct packed {
    pstate_e shallowest;
    logic    allDeep;
    logic    gC3;
    logic    gC6;
    logic    gC7;
    logic    flushed;
  } sampleInfo_t;

  // Strobes from control to datapath output registers
  typedef struct packed {
    logic snoopNext;
    logic flushNext;
    logic wakeNext;
  } ctrlStrobes_t;

endpackage

// File: rtl/pkg_idle_datapath.sv
module pkg_idle_datapath
  import pkg_idle_types::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CORES*STATE_W-1:0] coreStateIn,
  input  logic                         grantC3In,
  input  logic                         grantC6In,
  input  logic                         grantC7In,
  input  logic                         flushedIn,
  input  ctrlStrobes_t                 strobes,
  output sampleInfo_t                  info,
  output logic                         snoopable,
  output logic                         flushReq,
  output logic                         wake
);

  localparam int BUS_W = NUM_CORES * STATE_W;

  logic [BUS_W-1:0]   coreStateQ;
  logic               gC3Q, gC6Q, gC7Q, flushedQ;
  logic [STATE_W-1:0] runMin [NUM_CORES];

  // Input capture stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coreStateQ <= '0;
      gC3Q       <= 1'b0;
      gC6Q       <= 1'b0;
      gC7Q       <= 1'b0;
      flushedQ   <= 1'b0;
    end else begin
      coreStateQ <= coreStateIn;
      gC3Q       <= grantC3In;
      gC6Q       <= grantC6In;
      gC7Q       <= grantC7In;
      flushedQ   <= flushedIn;
    end
  end

  // Running minimum across cores gives the shallowest depth
  for (genvar i = 0; i < NUM_CORES; i++) begin : g_min
    logic [STATE_W-1:0] thisCore;
    assign thisCore = coreStateQ[i*STATE_W +: STATE_W];
    if (i == 0) begin : g_first
      assign runMin[i] = thisCore;
    end else begin : g_rest
      assign runMin[i] = (thisCore < runMin[i-1]) ? thisCore : runMin[i-1];
    end
  end

  always_comb begin
    info.shallowest = pstate_e'(runMin[NUM_CORES-1]);
    info.allDeep    = (runMin[NUM_CORES-1] == PS_C7);
    info.gC3        = gC3Q;
    info.gC6        = gC6Q;
    info.gC7        = gC7Q;
    info.flushed    = flushedQ;
  end

  // Output flag registers, loaded alongside the package state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snoopable <= 1'b0;
      flushReq  <= 1'b0;
      wake      <= 1'b0;
    end else begin
      snoopable <= strobes.snoopNext;
      flushReq  <= strobes.flushNext;
      wake      <= strobes.wakeNext;
    end
  end

endmodule

// File: rtl/pkg_idle_fsm.sv
module pkg_idle_fsm
  import pkg_idle_types::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  sampleInfo_t  info,
  output ctrlStrobes_t strobes,
  output pstate_e      curState
);

  pstate_e target;

  // Deepest state allowed by cores, grants and cache status
  always_comb begin
    target = PS_ACTIVE;
    if (info.shallowest >= PS_C3 && info.gC3)
      target = PS_C3;
    if (info.shallowest >= PS_C6 && info.gC6 && (!info.gC7 || info.allDeep))
      target = PS_C6;
    if (info.allDeep && info.gC7 && info.flushed)
      target = PS_C7;
  end

  always_comb begin
    strobes.snoopNext = (target == PS_C3) || (target == PS_C6);
    strobes.flushNext = info.allDeep && !info.flushed;
    strobes.wakeNext  = (curState != PS_ACTIVE) && (target == PS_ACTIVE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) curState <= PS_ACTIVE;
    else        curState <= target;
  end

endmodule

// File: rtl/pkg_idle_ctrl.sv
module pkg_idle_ctrl
  import pkg_idle_types::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CORES*STATE_W-1:0] coreState,
  input  logic                         grantC3,
  input  logic                         grantC6,
  input  logic                         grantC7,
  input  logic                         cacheFlushed,
  output logic [STATE_W-1:0]           pkgState,
  output logic                         snoopable,
  output logic                         flushReq,
  output logic                         wake
);

  sampleInfo_t  info;
  ctrlStrobes_t strobes;
  pstate_e      curState;

  pkg_idle_datapath #(.NUM_CORES(NUM_CORES)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .coreStateIn(coreState),
    .grantC3In  (grantC3),
    .grantC6In  (grantC6),
    .grantC7In  (grantC7),
    .flushedIn  (cacheFlushed),
    .strobes    (strobes),
    .info       (info),
    .snoopable  (snoopable),
    .flushReq   (flushReq),
    .wake       (wake)
  );

  pkg_idle_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .info    (info),
    .strobes (strobes),
    .curState(curState)
  );

  assign pkgState = curState;

endmodule

// File: rtl/pkg_idle_checker.sv
module pkg_idle_checker
  import pkg_idle_types::*;
#(
  parameter int NUM_CORES = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_CORES*STATE_W-1:0] coreState,
  input logic                         grantC3,
  input logic                         grantC6,
  input logic                         grantC7,
  input logic                         cacheFlushed,
  input logic [STATE_W-1:0]           pkgState,
  input logic                         snoopable,
  input logic                         flushReq,
  input logic                         wake
);

  logic anyActive;
  always_comb begin
    anyActive = 1'b0;
    for (int i = 0; i < NUM_CORES; i++)
      if (coreState[i*STATE_W +: STATE_W] == PS_ACTIVE) anyActive = 1'b1;
  end

  AST_SNOOP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    snoopable == (pkgState == PS_C3 || pkgState == PS_C6)); // R5

  AST_C3_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (pkgState == PS_C3) |-> $past(grantC3, 2)); // R2

  AST_C6_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (pkgState == PS_C6) |-> $past(grantC6, 2)); // R3

  AST_C7_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
    (pkgState == PS_C7) |-> ($past(grantC7, 2) && $past(cacheFlushed, 2))); // R4

  AST_C7_NO_FLUSH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (pkgState == PS_C7) |-> !flushReq); // R6

  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (pkgState == PS_ACTIVE && $past(pkgState) != PS_ACTIVE)); // R7

  AST_AWAKE_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    (pkgState != PS_ACTIVE) |-> !$past(anyActive, 2)); // R7

  AST_FLUSH_ONLY_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
    flushReq |-> !$past(cacheFlushed, 2)); // R6

endmodule

bind pkg_idle_ctrl pkg_idle_checker #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .coreState   (coreState),
  .grantC3     (grantC3),
  .grantC6     (grantC6),
  .grantC7     (grantC7),
  .cacheFlushed(cacheFlushed),
  .pkgState    (pkgState),
  .snoopable   (snoopable),
  .flushReq    (flushReq),
  .wake        (wake)
);

// File: tb/pkg_idle_ctrl_bench.sv
`timescale 1ns/1ps
module pkg_idle_ctrl_bench;

  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2*NC-1:0] coreState = '0;
  logic          grantC3 = 1'b0, grantC6 = 1'b0, grantC7 = 1'b0;
  logic          cacheFlushed = 1'b0;
  logic [1:0]    pkgState;
  logic          snoopable, flushReq, wake;

  int testsRun = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pkg_idle_ctrl #(.NUM_CORES(NC)) u_pkg_idle_ctrl (
    .clk(clk), .rst_n(rst_n), .coreState(coreState),
    .grantC3(grantC3), .grantC6(grantC6), .grantC7(grantC7),
    .cacheFlushed(cacheFlushed), .pkgState(pkgState),
    .snoopable(snoopable), .flushReq(flushReq), .wake(wake)
  );

  task automatic chk(input string req, input int got, input int exp);
    testsRun++;
    if (got != exp) begin
      failCount++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic setCores(input logic [1:0] c0, c1, c2, c3);
    coreState = {c3, c2, c1, c0};
  endtask

  task automatic setGrants(input logic g3, g6, g7);
    grantC3 = g3; grantC6 = g6; grantC7 = g7;
  endtask

  // Two edges: capture then update; sample at following falling edge
  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkOut(input string req, input int st, sn, fr, wk);
    chk({req, " state"}, pkgState, st);
    chk({req, " snoop"}, snoopable, sn);
    chk({req, " flushReq"}, flushReq, fr);
    chk({req, " wake"}, wake, wk);
  endtask

  task automatic tReset();
    checkOut("R1 reset", 0, 0, 0, 0);
  endtask

  task automatic tLightAndLatency();
    setGrants(1, 1, 0);
    setCores(1, 1, 2, 3);
    @(posedge clk); @(negedge clk);
    chk("R9 one edge", pkgState, 0);
    @(posedge clk); @(negedge clk);
    checkOut("R2 light", 1, 1, 0, 0);
  endtask

  task automatic tNoGrantWake();
    setGrants(0, 1, 0);
    settle();
    checkOut("R8 light withdrawn", 0, 0, 0, 1);
    @(posedge clk); @(negedge clk);
    chk("R7 wake one cycle", wake, 0);
  endtask

  task automatic tMedium();
    setGrants(1, 1, 0);
    setCores(2, 2, 3, 2);
    settle();
    checkOut("R3 medium", 2, 1, 0, 0);
  endtask

  task automatic tMediumBlocked();
    setGrants(1, 1, 1);
    setCores(2, 3, 3, 3);
    settle();
    checkOut("R3 deep grant blocks medium", 1, 1, 0, 0);
  endtask

  task automatic tFlushThenDeep();
    setGrants(1, 1, 1);
    cacheFlushed = 1'b0;
    setCores(3, 3, 3, 3);
    settle();
    checkOut("R6 waiting for flush", 2, 1, 1, 0);
    cacheFlushed = 1'b1;
    settle();
    checkOut("R4 deep", 3, 0, 0, 0);
  endtask

  task automatic tWithdraw();
    setGrants(1, 1, 0);
    settle();
    checkOut("R8 deep withdrawn", 2, 1, 0, 0);
    setGrants(1, 0, 0);
    settle();
    checkOut("R8 medium withdrawn", 1, 1, 0, 0);
  endtask

  task automatic tDeepWake();
    setGrants(1, 1, 1);
    cacheFlushed = 1'b1;
    setCores(3, 3, 3, 3);
    settle();
    chk("R4 deep again", pkgState, 3);
    setCores(3, 3, 0, 3);
    settle();
    checkOut("R7 wake from deep", 0, 0, 0, 1);
  endtask

  task automatic tRace();
    setGrants(1, 1, 1);
    cacheFlushed = 1'b0;
    setCores(3, 3, 3, 3);
    settle();
    checkOut("R6 race setup", 2, 1, 1, 0);
    cacheFlushed = 1'b1;
    setCores(0, 3, 3, 3);
    @(posedge clk); @(negedge clk);
    chk("R9 race one edge", pkgState, 2);
    @(posedge clk); @(negedge clk);
    checkOut("R7 wake beats flush", 0, 0, 0, 1);
    @(posedge clk); @(negedge clk);
    chk("R4 never deep after race", pkgState, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tLightAndLatency();
    tNoGrantWake();
    tMedium();
    tMediumBlocked();
    tFlushThenDeep();
    tWithdraw();
    tDeepWake();
    tRace();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, failCount);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      testsRun++;
      failCount++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", testsRun, failCount);
      $finish;
    end
  end

endmodule